// File: doc/BRIEF.md
# DRAM Read Auto-Precharge Selector

This block sits in a DDR memory controller between the stage that splits transactions and the stage that issues commands. It accepts one read transaction at a time, described by a target bank, a row and a length in bytes. It cuts the transaction into fixed 16-byte DRAM bursts. It then presents one read command per burst on a valid/ready output, carrying the bank, the row, the burst index and first/last markers.

For each burst it picks between a plain read and a read with auto-precharge. Two policies set this choice:

- **Global switch:** closes the row after every burst.
- **Per-bank mask:** one bit per bank. It closes the row only after the final burst of a transaction to a bank whose bit is set.

The global switch wins when both apply. Both controls are captured when a transaction is accepted and stay fixed for all of its bursts. A new transaction is accepted only once the last burst of the previous one has been handed off.

Top module: `ap_read_selector`

## Requirements
- R1: While reset is asserted and right after it is released, `cmd_valid` is 0 and `req_ready` is 1.
- R2: A transaction of N bytes yields ceil(N/16) bursts, and a length of 0 yields one burst. With N of 16 or less the single burst has both `cmd_first` and `cmd_last` set to 1.
- R3: Bursts appear in order with `cmd_beat` running 0, 1, ... up to the burst count minus 1. Each burst carries the accepted bank and row. `cmd_first` is 1 only on beat 0 and `cmd_last` is 1 only on the final beat. `cmd_valid` goes to 0 after the final burst is taken.
- R4: With the global switch set at acceptance, every burst has `cmd_autopre` = 1 (read with auto-precharge).
- R5: With the global switch clear and the mask bit at index `req_bank` set, only the final burst has `cmd_autopre` = 1.
- R6: When the global switch and the target bank's mask bit are both set, every burst has `cmd_autopre` = 1.
- R7: With the global switch clear and the target bank's mask bit clear, every burst has `cmd_autopre` = 0.
- R8: Mask bits of banks other than the target have no effect on `cmd_autopre`.
- R9: While `cmd_valid` is 1 and `cmd_ready` is 0, the presented command holds its beat and fields.
- R10: `req_ready` is 0 while a transaction is in flight. Changes to the global switch or the mask after acceptance do not alter that transaction's bursts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Transaction offered |
| req_ready | output | 1 | Block idle, offer taken on this edge |
| req_bank | input | BANK_W (3) | Target bank |
| req_row | input | ROW_W (14) | Target row |
| req_bytes | input | SIZE_W (8) | Transaction length in bytes |
| glob_ap_en | input | 1 | Global auto-precharge switch |
| bank_ap_mask | input | BANKS (8) | Per-bank last-burst auto-precharge mask, bit i for bank i |
| cmd_valid | output | 1 | Burst command presented |
| cmd_ready | input | 1 | Issue path takes the command |
| cmd_bank | output | BANK_W (3) | Bank of the burst |
| cmd_row | output | ROW_W (14) | Row of the burst |
| cmd_beat | output | IDX_W (4) | Burst index within the transaction |
| cmd_first | output | 1 | First burst of the transaction |
| cmd_last | output | 1 | Final burst of the transaction |
| cmd_autopre | output | 1 | 1 = read with auto-precharge, 0 = plain read |

## Verification
The bench builds the block with its default parameters: eight banks, 16-byte bursts and an 8-bit length field. With these values a 255-byte request drives the burst index through all sixteen values of its four-bit counter. Zero-length and sub-burst lengths reach the single-burst corner, and every mask bit position can be targeted. Vectors pair each bank with masks that select it, miss it, or compete with the global switch. Some vectors stall the output every other cycle, and every vector flips the controls after acceptance.

// File: rtl/ap_pkg.sv
package ap_pkg;

  typedef enum logic {
    RD_PLAIN = 1'b0,
    RD_AUTOPRE = 1'b1
  } rd_kind_e;

  // index of the final burst for a length in bytes; zero length still makes one burst
  function automatic int unsigned ap_last_beat(input int unsigned nbytes,
                                               input int unsigned off_w);
    if (nbytes == 0) return 0;
    return (nbytes - 1) >> off_w;
  endfunction

  // kind of read for one burst: global switch first, then the bank's last-burst mask
  function automatic rd_kind_e ap_pick(input logic glob, input logic bank_sel,
                                       input logic is_last);
    if (glob) return RD_AUTOPRE;
    if (bank_sel && is_last) return RD_AUTOPRE;
    return RD_PLAIN;
  endfunction

endpackage

// File: rtl/ap_burst_seq.sv
module ap_burst_seq
  import ap_pkg::*;
#(
  parameter int SIZE_W = 8,
  parameter int BURST_BYTES = 16,
  parameter int ROW_W = 14,
  parameter int BANK_W = 3,
  localparam int OFF_W = $clog2(BURST_BYTES),
  localparam int IDX_W = SIZE_W - OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc,
  input  logic [BANK_W-1:0] in_bank,
  input  logic [ROW_W-1:0]  in_row,
  input  logic [SIZE_W-1:0] in_bytes,
  input  logic              adv,
  output logic              busy,
  output logic [IDX_W-1:0]  beat,
  output logic              first,
  output logic              last,
  output logic [BANK_W-1:0] bank_q,
  output logic [ROW_W-1:0]  row_q
);

  logic [IDX_W-1:0] last_beat_q;
  logic [IDX_W-1:0] last_beat_in;

  assign last_beat_in = IDX_W'(ap_last_beat(int'(in_bytes), OFF_W));
  assign first = (beat == '0);
  assign last  = (beat == last_beat_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy        <= 1'b0;
      beat        <= '0;
      last_beat_q <= '0;
      bank_q      <= '0;
      row_q       <= '0;
    end else if (acc) begin
      busy        <= 1'b1;
      beat        <= '0;
      last_beat_q <= last_beat_in;
      bank_q      <= in_bank;
      row_q       <= in_row;
    end else if (adv) begin
      if (last) busy <= 1'b0;
      else beat <= beat + 1'b1;
    end
  end

  // R3
  beat_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !last) |=> (busy && beat == $past(beat) + 1'b1));

  // R2
  short_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && (in_bytes <= SIZE_W'(BURST_BYTES))) |=> (busy && first && last));

  // R3
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && last && !acc) |=> !busy);

endmodule

// File: rtl/ap_policy.sv
module ap_policy
  import ap_pkg::*;
#(
  parameter int BANKS = 8,
  localparam int BANK_W = $clog2(BANKS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc,
  input  logic              glob_in,
  input  logic [BANKS-1:0]  mask_in,
  input  logic              active,
  input  logic [BANK_W-1:0] bank,
  input  logic              last,
  output logic              glob_q,
  output logic              bank_sel,
  output logic              autopre
);

  logic [BANKS-1:0] mask_q;
  logic [BANKS-1:0] hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      glob_q <= 1'b0;
      mask_q <= '0;
    end else if (acc) begin
      glob_q <= glob_in;
      mask_q <= mask_in;
    end
  end

  for (genvar b = 0; b < BANKS; b++) begin : g_hit
    assign hit[b] = mask_q[b] && (bank == BANK_W'(b));
  end

  assign bank_sel = |hit;
  assign autopre  = (ap_pick(glob_q, bank_sel, last) == RD_AUTOPRE);

  // R4
  glob_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && glob_q) |-> autopre);

  // R5
  mid_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !glob_q && !last) |-> !autopre);

  // R8
  one_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit));

endmodule

// File: rtl/ap_read_selector.sv
module ap_read_selector #(
  parameter int BANKS = 8,
  parameter int ROW_W = 14,
  parameter int SIZE_W = 8,
  parameter int BURST_BYTES = 16,
  localparam int BANK_W = $clog2(BANKS),
  localparam int OFF_W = $clog2(BURST_BYTES),
  localparam int IDX_W = SIZE_W - OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [BANK_W-1:0] req_bank,
  input  logic [ROW_W-1:0]  req_row,
  input  logic [SIZE_W-1:0] req_bytes,
  input  logic              glob_ap_en,
  input  logic [BANKS-1:0]  bank_ap_mask,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [BANK_W-1:0] cmd_bank,
  output logic [ROW_W-1:0]  cmd_row,
  output logic [IDX_W-1:0]  cmd_beat,
  output logic              cmd_first,
  output logic              cmd_last,
  output logic              cmd_autopre
);

  logic busy;
  logic acc;
  logic adv;
  logic glob_q;
  logic bank_sel;

  assign req_ready = !busy;
  assign acc       = req_valid && req_ready;
  assign cmd_valid = busy;
  assign adv       = cmd_valid && cmd_ready;

  ap_burst_seq #(
    .SIZE_W(SIZE_W), .BURST_BYTES(BURST_BYTES), .ROW_W(ROW_W), .BANK_W(BANK_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .acc(acc),
    .in_bank(req_bank), .in_row(req_row), .in_bytes(req_bytes),
    .adv(adv), .busy(busy), .beat(cmd_beat),
    .first(cmd_first), .last(cmd_last),
    .bank_q(cmd_bank), .row_q(cmd_row)
  );

  ap_policy #(.BANKS(BANKS)) u_pol (
    .clk(clk), .rst_n(rst_n), .acc(acc),
    .glob_in(glob_ap_en), .mask_in(bank_ap_mask),
    .active(cmd_valid), .bank(cmd_bank), .last(cmd_last),
    .glob_q(glob_q), .bank_sel(bank_sel), .autopre(cmd_autopre)
  );

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_beat) &&
      $stable(cmd_bank) && $stable(cmd_row) && $stable(cmd_autopre)));

  // R10
  busy_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> !req_ready);

  // R10
  ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !acc) |=> ($stable(glob_q) && $stable(bank_sel)));

  // R3
  start_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> (cmd_valid && cmd_first));

endmodule

// File: tb/sim_ap_read_selector.sv
module sim_ap_read_selector;

  localparam int NV = 10;
  localparam int unsigned T_BANK  [NV] = '{2, 2, 2, 5, 5, 0, 7, 3, 7, 1};
  localparam int unsigned T_BYTES [NV] = '{32, 32, 32, 64, 64, 16, 0, 17, 255, 1};
  localparam bit          T_GLOB  [NV] = '{0, 1, 0, 1, 0, 0, 0, 0, 0, 1};
  localparam int unsigned T_MASK  [NV] = '{8'h00, 8'h00, 8'h04, 8'h20, 8'hDB,
                                          8'h01, 8'h80, 8'h08, 8'h80, 8'h00};
  localparam int unsigned T_NB    [NV] = '{2, 2, 2, 4, 4, 1, 1, 2, 16, 1};
  localparam bit          T_STALL [NV] = '{0, 0, 0, 1, 0, 0, 0, 1, 1, 0};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [2:0] req_bank = '0;
  logic [13:0] req_row = '0;
  logic [7:0] req_bytes = '0;
  logic glob_ap_en = 1'b0;
  logic [7:0] bank_ap_mask = '0;
  logic cmd_valid;
  logic cmd_ready = 1'b0;
  logic [2:0] cmd_bank;
  logic [13:0] cmd_row;
  logic [3:0] cmd_beat;
  logic cmd_first;
  logic cmd_last;
  logic cmd_autopre;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  ap_read_selector u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_bank(req_bank), .req_row(req_row), .req_bytes(req_bytes),
    .glob_ap_en(glob_ap_en), .bank_ap_mask(bank_ap_mask),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_bank(cmd_bank),
    .cmd_row(cmd_row), .cmd_beat(cmd_beat), .cmd_first(cmd_first),
    .cmd_last(cmd_last), .cmd_autopre(cmd_autopre)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic bit exp_ap(input bit g, input int unsigned m,
                                input int unsigned bank, input int beat,
                                input int nb);
    bit own = ((m >> bank) & 1) != 0;
    return g || (own && beat == nb - 1);
  endfunction

  task automatic run_txn(input int unsigned bank, input int unsigned row,
                         input int unsigned nbytes, input bit g,
                         input int unsigned m, input int nb, input bit stall,
                         input string tag);
    int beat = 0;
    int guard = 0;
    bit tog = 1'b0;
    @(negedge clk);
    req_valid = 1'b1;
    req_bank = 3'(bank);
    req_row = 14'(row);
    req_bytes = 8'(nbytes);
    glob_ap_en = g;
    bank_ap_mask = 8'(m);
    cmd_ready = 1'b0;
    chk(req_ready == 1'b1, "R10", "idle ready", int'(req_ready), 1);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    glob_ap_en = !g;
    bank_ap_mask = ~8'(m);
    while (beat < nb && guard < 200) begin
      cmd_ready = stall ? tog : 1'b1;
      tog = !tog;
      chk(cmd_valid == 1'b1, "R3", "valid in flight", int'(cmd_valid), 1);
      chk(req_ready == 1'b0, "R10", "ready while busy", int'(req_ready), 0);
      if (cmd_ready) begin
        chk(int'(cmd_bank) == int'(bank), "R3", "bank", int'(cmd_bank), int'(bank));
        chk(int'(cmd_row) == int'(row), "R3", "row", int'(cmd_row), int'(row));
        chk(int'(cmd_beat) == beat, "R3", "beat", int'(cmd_beat), beat);
        chk(cmd_first == (beat == 0), "R2", "first", int'(cmd_first), int'(beat == 0));
        chk(cmd_last == (beat == nb - 1), "R2", "last", int'(cmd_last), int'(beat == nb - 1));
        chk(cmd_autopre == exp_ap(g, m, bank, beat, nb), tag, "autopre",
            int'(cmd_autopre), int'(exp_ap(g, m, bank, beat, nb)));
        beat++;
      end else begin
        chk(int'(cmd_beat) == beat, "R9", "stalled beat", int'(cmd_beat), beat);
      end
      @(posedge clk);
      @(negedge clk);
      guard++;
    end
    cmd_ready = 1'b0;
    chk(beat == nb, "R2", "burst count", beat, nb);
    chk(cmd_valid == 1'b0, "R3", "valid after final", int'(cmd_valid), 0);
    chk(req_ready == 1'b1, "R10", "ready after final", int'(req_ready), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(cmd_valid == 1'b0, "R1", "valid in reset", int'(cmd_valid), 0);
    chk(req_ready == 1'b1, "R1", "ready in reset", int'(req_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cmd_valid == 1'b0, "R1", "valid after reset", int'(cmd_valid), 0);
    chk(req_ready == 1'b1, "R1", "ready after reset", int'(req_ready), 1);

    for (int i = 0; i < NV; i++) begin
      string tag;
      bit own = ((T_MASK[i] >> T_BANK[i]) & 1) != 0;
      if (T_GLOB[i] && own) tag = "R6";
      else if (T_GLOB[i]) tag = "R4";
      else if (own) tag = "R5";
      else if (T_MASK[i] != 0) tag = "R8";
      else tag = "R7";
      run_txn(T_BANK[i], 100 + i, T_BYTES[i], T_GLOB[i], T_MASK[i], T_NB[i],
              T_STALL[i], tag);
    end

    // R10: back-to-back with controls the reverse of the previous vector
    run_txn(4, 16383, 48, 1'b0, 8'h10, 3, 1'b0, "R5");
    run_txn(4, 0, 48, 1'b1, 8'hEF, 3, 1'b1, "R4");

    // R1: reset in the middle of a transaction
    @(negedge clk);
    req_valid = 1'b1;
    req_bytes = 8'd128;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    chk(cmd_valid == 1'b0, "R1", "valid after mid reset", int'(cmd_valid), 0);
    chk(req_ready == 1'b1, "R1", "ready after mid reset", int'(req_ready), 1);
    rst_n = 1'b1;
    run_txn(6, 7, 20, 1'b0, 8'h40, 2, 1'b0, "R5");

    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: got 1 expected 0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule